// File: doc/BRIEF.md
# Microprogram Sequencer with Fixed and Paged Control Store

This block steps through microprograms that steer a custom compute unit. A start pulse carries an address with a one-bit region flag. With the flag clear, the address points straight into the fixed part of an on-chip control store. That part holds frequently used routines, written beforehand through a preload port. With the flag set, the address is a location in external memory. The block looks that location up in a small residence table. On a hit it runs the copy already held in the paged part of the store. On a miss it first copies the routine from memory into a paged slot, records the mapping, and then runs it.

Execution uses a store address register and a microinstruction register, which is the store's registered read output. One word is taken per cycle. Operation words go to the compute unit. Skip and back words change the sequence, and an end word finishes the routine and raises a one-cycle completion pulse.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `cu_valid`, `done` and `mem_rd` are all 0.
- R2: A start with `start_addr[16]`=0 runs from fixed-store address `start_addr[5:0]`. The first word's effect is visible after the second rising edge that follows the edge accepting `start`, and no memory read occurs.
- R3: Each word's kind is in bits [63:62]: 00 operation, 01 skip, 10 back, 11 end. An operation word drives `cu_valid`=1 for one cycle with `cu_word` equal to its bits [61:0]. Successive words follow one per cycle.
- R4: A skip word advances the address by 2 when `cu_cond` is 1 in its execute cycle, and by 1 otherwise. It produces no compute-unit output.
- R5: A back word returns to the routine's first word, whether that word is in the fixed store or in a paged slot.
- R6: An end word raises `done` for exactly one cycle, one cycle after the end word executes, never together with `cu_valid`. `busy` is 0 in that same cycle.
- R7: A start with `start_addr[16]`=1 whose address A is not in the table holds `mem_rd`=1 for L+1 cycles, starting the cycle after acceptance, with `mem_addr` = A, A+1, ... one per cycle. L is the routine length including its end word, at most 8. The last read is a spare. The first word's effect is visible L+3 edges after acceptance.
- R8: A start with the flag set whose address is already resident issues no memory read and has the same timing as a fixed-store start.
- R9: The paged region has 4 slots of 8 words. Misses fill slots in round-robin order starting at slot 0, and replacing a slot drops the mapping it held, so a later start at the dropped address misses again.
- R10: A `start` pulse while `busy` is 1 is ignored and does not disturb the running routine.
- R11: A preload write (`pl_we`) stores `pl_data` at fixed-store address `pl_addr` when the block is idle. While busy it is discarded, even in a cycle where a paged copy writes the store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a routine at `start_addr` |
| start_addr | input | 17 | Bit 16 region flag (1 = memory), bits 15:0 address |
| busy | output | 1 | Copying or executing |
| pl_we | input | 1 | Fixed-store preload write enable |
| pl_addr | input | 5 | Fixed-store preload address |
| pl_data | input | 64 | Fixed-store preload word |
| mem_rd | output | 1 | Memory read request, data returns next cycle |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 64 | Memory read data |
| cu_cond | input | 1 | Condition from the compute unit, used by skip |
| cu_valid | output | 1 | Operation word valid |
| cu_word | output | 62 | Operation payload |
| done | output | 1 | Routine finished pulse |

## Verification
The store has a single write port, so a preload write and a paged-copy write can fall in the same cycle. The bench provokes this by asserting a preload during the data phase of a miss copy. It then checks both sides: the copied routine runs word for word, and a later run of the targeted fixed routine shows the original contents. A start pulse during execution is the second collision, and it is judged by comparing the full per-cycle trace against the reference model.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UW = 64;
  localparam int PW = UW - 2;

  typedef enum logic [1:0] {
    K_OP   = 2'b00,
    K_SKIP = 2'b01,
    K_BACK = 2'b10,
    K_END  = 2'b11
  } ukind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_PRIME,
    S_RUN
  } ustate_t;

  function automatic ukind_t kind_of(input logic [UW-1:0] w);
    return ukind_t'(w[UW-1:UW-2]);
  endfunction
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 6,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2**AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_restab.sv
module useq_restab #(
  parameter int NE   = 4,
  parameter int TAGW = 16,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAGW-1:0] lk_tag,
  output logic            hit,
  output logic [IW-1:0]   hit_idx,
  input  logic            ins_en,
  input  logic [IW-1:0]   ins_idx,
  input  logic [TAGW-1:0] ins_tag,
  output logic [IW-1:0]   victim
);
  logic [NE-1:0]   valid;
  logic [TAGW-1:0] tags [NE];
  logic [NE-1:0]   match;

  for (genvar g = 0; g < NE; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == lk_tag);
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = 0; i < NE; i++) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= '0;
      victim <= '0;
    end else if (ins_en) begin
      valid[ins_idx] <= 1'b1;
      victim         <= (victim == IW'(NE-1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tags[ins_idx] <= ins_tag;
  end

  // one mapping per memory address at most
  assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // replacement pointer only moves on an insert
  assert_victim_steady_R9: assert property (@(posedge clk) disable iff (rst)
    !ins_en |=> $stable(victim));
endmodule

// File: rtl/useq_nextpc.sv
module useq_nextpc
  import useq_pkg::*;
#(
  parameter int AW = 6
) (
  input  ukind_t        kind,
  input  logic          cond,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] entry,
  output logic [AW-1:0] npc
);
  always_comb begin
    unique case (kind)
      K_SKIP:  npc = cond ? pc + AW'(2) : pc + AW'(1);
      K_BACK:  npc = entry;
      default: npc = pc + AW'(1);
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int CS_AW  = 6,
  parameter int FIX_AW = 5,
  parameter int NSLOT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MEM_AW:0]   start_addr,
  output logic              busy,
  input  logic              pl_we,
  input  logic [FIX_AW-1:0] pl_addr,
  input  logic [UW-1:0]     pl_data,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [UW-1:0]     mem_rdata,
  input  logic              cu_cond,
  output logic              cu_valid,
  output logic [PW-1:0]     cu_word,
  output logic              done
);
  localparam int FIX_N   = 2**FIX_AW;
  localparam int PAGE_N  = 2**CS_AW - FIX_N;
  localparam int SLOT    = PAGE_N / NSLOT;
  localparam int SLOT_AW = $clog2(SLOT);
  localparam int IDX_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  function automatic logic [CS_AW-1:0] slot_base(input logic [IDX_W-1:0] i);
    return CS_AW'(FIX_N) + (CS_AW'(i) << SLOT_AW);
  endfunction

  ustate_t             state;
  logic [CS_AW-1:0]    csar, entry_q, ld_ptr, rd_addr, npc, wr_addr;
  logic [UW-1:0]       mir, wr_data;
  logic                wr_en, rvalid_q, ld_last, hit;
  logic [SLOT_AW:0]    ld_cnt;
  logic [IDX_W-1:0]    ld_slot, hit_idx, victim;
  logic [MEM_AW-1:0]   ld_tag;
  ukind_t              kind;
  logic                flag;
  logic [MEM_AW-1:0]   loc;

  assign flag = start_addr[MEM_AW];
  assign loc  = start_addr[MEM_AW-1:0];
  assign kind = kind_of(mir);
  assign busy = (state != S_IDLE);

  // single write port: copy owns it while loading, preload only when idle
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = CS_AW'(pl_addr);
    wr_data = pl_data;
    if (state == S_LOAD) begin
      wr_en   = rvalid_q;
      wr_addr = ld_ptr;
      wr_data = mem_rdata;
    end else if (state == S_IDLE) begin
      wr_en = pl_we;
    end
  end

  assign rd_addr = (state == S_RUN) ? npc : csar;
  assign ld_last = rvalid_q &&
                   ((kind_of(mem_rdata) == K_END) || (ld_cnt == (SLOT_AW+1)'(SLOT-1)));

  useq_store #(.AW(CS_AW), .W(UW)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mir)
  );

  useq_restab #(.NE(NSLOT), .TAGW(MEM_AW), .IW(IDX_W)) u_tab (
    .clk(clk), .rst(rst), .lk_tag(loc), .hit(hit), .hit_idx(hit_idx),
    .ins_en(state == S_LOAD && ld_last), .ins_idx(ld_slot), .ins_tag(ld_tag),
    .victim(victim)
  );

  useq_nextpc #(.AW(CS_AW)) u_npc (
    .kind(kind), .cond(cu_cond), .pc(csar), .entry(entry_q), .npc(npc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      csar      <= '0;
      entry_q   <= '0;
      ld_ptr    <= '0;
      ld_cnt    <= '0;
      ld_slot   <= '0;
      ld_tag    <= '0;
      rvalid_q  <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      cu_valid  <= 1'b0;
      cu_word   <= '0;
      done      <= 1'b0;
    end else begin
      cu_valid <= 1'b0;
      done     <= 1'b0;
      rvalid_q <= mem_rd;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            if (!flag) begin
              csar    <= loc[CS_AW-1:0];
              entry_q <= loc[CS_AW-1:0];
              state   <= S_PRIME;
            end else if (hit) begin
              csar    <= slot_base(hit_idx);
              entry_q <= slot_base(hit_idx);
              state   <= S_PRIME;
            end else begin
              ld_slot  <= victim;
              ld_ptr   <= slot_base(victim);
              ld_cnt   <= '0;
              ld_tag   <= loc;
              mem_rd   <= 1'b1;
              mem_addr <= loc;
              state    <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (rvalid_q) begin
            ld_ptr <= ld_ptr + 1'b1;
            ld_cnt <= ld_cnt + 1'b1;
          end
          if (ld_last) begin
            mem_rd  <= 1'b0;
            csar    <= slot_base(ld_slot);
            entry_q <= slot_base(ld_slot);
            state   <= S_PRIME;
          end else begin
            mem_addr <= mem_addr + 1'b1;
          end
        end
        S_PRIME: state <= S_RUN;
        S_RUN: begin
          csar <= npc;
          if (kind == K_OP) begin
            cu_valid <= 1'b1;
            cu_word  <= mir[PW-1:0];
          end
          if (kind == K_END) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_memrd_in_copy_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (state == S_LOAD));
  assert_copy_in_slot_R7: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && rvalid_q) |-> (ld_cnt < (SLOT_AW+1)'(SLOT)));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_op_R6: assert property (@(posedge clk) disable iff (rst)
    !(done && cu_valid));
  assert_op_from_run_R3: assert property (@(posedge clk) disable iff (rst)
    cu_valid |-> ($past(state) == S_RUN));
endmodule

// File: tb/useq_sequencer_bench.sv
`timescale 1ns/1ps
module useq_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [16:0] start_addr = '0;
  logic        busy;
  logic        pl_we = 1'b0;
  logic [4:0]  pl_addr = '0;
  logic [63:0] pl_data = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        cu_cond = 1'b0;
  logic        cu_valid;
  logic [61:0] cu_word;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  useq_sequencer u_useq_sequencer (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .busy(busy),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cu_cond(cu_cond), .cu_valid(cu_valid), .cu_word(cu_word), .done(done)
  );

  // behavioural external memory: one cycle read latency
  logic [63:0] bmem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= bmem[mem_addr[7:0]];

  // reference state
  logic [63:0] fix_img [32];
  int  mt [4];
  bit  mv [4];
  int  mvic = 0;

  bit          q_v[$];
  logic [61:0] q_w[$];
  bit          q_d[$];
  bit          q_r[$];
  int          q_a[$];
  bit          q_b[$];

  function automatic logic [63:0] mk(input logic [1:0] k, input logic [61:0] p);
    return {k, p};
  endfunction

  function automatic void push(bit v, logic [61:0] w, bit d, bit r, int a, bit b);
    q_v.push_back(v); q_w.push_back(w); q_d.push_back(d);
    q_r.push_back(r); q_a.push_back(a); q_b.push_back(b);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input int a, input logic [63:0] w);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 5'(a); pl_data = w;
    @(negedge clk);
    pl_we = 1'b0;
    fix_img[a] = w;
  endtask

  // poke: 0 none, 1 start pulse while busy, 2 preload while busy
  task automatic run(input bit flag, input int addr, input int k_cond,
                     input string req, input int poke);
    bit hit = 1'b0;
    int hslot = 0;
    int len = 0;
    int first, pc, r, steps;
    logic [63:0] w;
    q_v.delete(); q_w.delete(); q_d.delete(); q_r.delete(); q_a.delete(); q_b.delete();
    if (flag) for (int i = 0; i < 4; i++) if (mv[i] && mt[i] == addr) begin hit = 1'b1; hslot = i; end
    if (flag && !hit) begin
      do len++; while (len < 8 && bmem[addr+len-1][63:62] != 2'b11);
      for (int t = 1; t <= len + 1; t++) push(0, '0, 0, 1, addr + t - 1, 1);
      push(0, '0, 0, 0, 0, 1);
      push(0, '0, 0, 0, 0, 1);
      first = len + 3;
      mt[mvic] = addr; mv[mvic] = 1'b1; mvic = (mvic + 1) % 4;
    end else begin
      push(0, '0, 0, 0, 0, 1);
      push(0, '0, 0, 0, 0, 1);
      first = 2;
    end
    pc = 0; r = first; steps = 0;
    forever begin
      w = flag ? bmem[addr+pc] : fix_img[addr+pc];
      steps++;
      if (steps > 500) break;
      case (w[63:62])
        2'b00: begin push(1, w[61:0], 0, 0, 0, 1); pc++; end
        2'b01: begin push(0, '0, 0, 0, 0, 1); pc += (r >= k_cond) ? 2 : 1; end
        2'b10: begin push(0, '0, 0, 0, 0, 1); pc = 0; end
        default: begin push(0, '0, 1, 0, 0, 0); break; end
      endcase
      r++;
    end
    @(negedge clk);
    start = 1'b1; start_addr = {flag, 16'(addr)};
    for (int t = 1; t <= q_v.size(); t++) begin
      @(negedge clk);
      start = 1'b0; pl_we = 1'b0;
      cu_cond = (t >= k_cond);
      if (poke == 1 && t == 3) begin start = 1'b1; start_addr = {1'b1, 16'd32}; end
      if (poke == 2 && t == 3) begin pl_we = 1'b1; pl_addr = 5'd0; pl_data = mk(2'b00, 62'h77); end
      check(cu_valid == q_v[t-1] && (!q_v[t-1] || cu_word == q_w[t-1]) &&
            done == q_d[t-1] && mem_rd == q_r[t-1] &&
            (!q_r[t-1] || mem_addr == 16'(q_a[t-1])) && busy == q_b[t-1],
            req, $sformatf("cycle %0d v/d/r/b word addr", t),
            {cu_valid, done, mem_rd, busy, 60'(cu_word ^ 62'(mem_addr))},
            {q_v[t-1], q_d[t-1], q_r[t-1], q_b[t-1], 60'(q_w[t-1] ^ 62'(q_a[t-1]))});
    end
    @(negedge clk);
    start = 1'b0; pl_we = 1'b0;
    check(!busy && !cu_valid && !done && !mem_rd, req, "idle after end",
          {busy, cu_valid, done, mem_rd}, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = '0;
    for (int i = 0; i < 4; i++) begin mt[i] = 0; mv[i] = 1'b0; end
    bmem[16] = mk(2'b00, 62'h101); bmem[17] = mk(2'b00, 62'h102); bmem[18] = mk(2'b11, '0);
    bmem[32] = mk(2'b00, 62'h201); bmem[33] = mk(2'b01, '0); bmem[34] = mk(2'b00, 62'h202);
    bmem[35] = mk(2'b00, 62'h203); bmem[36] = mk(2'b11, '0);
    bmem[48] = mk(2'b00, 62'h301); bmem[49] = mk(2'b11, '0);
    bmem[64] = mk(2'b00, 62'h401); bmem[65] = mk(2'b01, '0); bmem[66] = mk(2'b10, '0);
    bmem[67] = mk(2'b11, '0);
    bmem[80] = mk(2'b00, 62'h501); bmem[81] = mk(2'b00, 62'h502); bmem[82] = mk(2'b00, 62'h503);
    bmem[83] = mk(2'b11, '0);

    repeat (4) @(negedge clk);
    check(!busy && !cu_valid && !done && !mem_rd, "R1", "outputs in reset",
          {busy, cu_valid, done, mem_rd}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !cu_valid && !done && !mem_rd, "R1", "outputs after reset",
          {busy, cu_valid, done, mem_rd}, 0);

    preload(0, mk(2'b00, 62'h3FFF_FFFF_FFFF_FFF0));
    preload(1, mk(2'b00, 62'h2AAA_5555_AAAA_5555));
    preload(2, mk(2'b11, '0));
    preload(4, mk(2'b00, 62'h31));
    preload(5, mk(2'b01, '0));
    preload(6, mk(2'b10, '0));
    preload(7, mk(2'b00, 62'h32));
    preload(8, mk(2'b11, '0));
    preload(10, mk(2'b01, '0));
    preload(11, mk(2'b00, 62'h41));
    preload(12, mk(2'b00, 62'h42));
    preload(13, mk(2'b11, '0));

    run(0, 0, 1000, "R2", 0);
    run(0, 0, 1000, "R3", 0);
    run(0, 4, 12, "R5", 0);
    run(0, 10, 0, "R4", 0);
    run(0, 10, 1000, "R4", 0);
    run(0, 10, 1000, "R6", 0);
    run(1, 16, 1000, "R7", 0);
    run(1, 16, 1000, "R8", 0);
    run(1, 32, 0, "R7", 0);
    run(1, 48, 1000, "R7", 0);
    run(1, 64, 9, "R5", 0);
    run(1, 80, 1000, "R9", 0);
    run(1, 16, 1000, "R9", 0);
    run(1, 48, 1000, "R9", 0);
    run(0, 0, 1000, "R10", 1);
    run(1, 32, 1000, "R11", 2);
    run(0, 0, 1000, "R11", 0);
    preload(1, mk(2'b00, 62'h99));
    run(0, 0, 1000, "R11", 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule